// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block resolves read-after-write dependencies for the instruction in the execute stage of a five-stage in-order pipeline. It chooses where each of the two ALU operands comes from. A source register is normally taken from the value read during decode and held in the ID/EX register. When an older instruction that has not yet written back targets that register, the block instead supplies the newer value. That value can be the ALU result held in EX/MEM or the write-back value held in MEM/WB.

The block carries its own copy of the destination register number and the register-write enable. Each cycle it takes these from the instruction leaving execute and passes them through two tag stages, one matching EX/MEM and one matching MEM/WB. Two comparators check each source index against both tag stages. For each operand, the block drives a 2-bit select code and the selected operand value. Writes to register zero are never forwarded, because that register always reads as zero. If both later stages hold the same register, the younger instruction in EX/MEM wins.

Top module: `alu_fwd_unit`

## Requirements
- R1: While reset is asserted, both tag stages are cleared. In the first cycle after release, both selects are 00 whatever the source indices, and each operand equals its ID/EX value.
- R2: If the EX/MEM tag has its write enable set and its destination equals a source index, that operand's select is 10 and the operand equals `mem_result`. The EX/MEM tag is the one from the instruction issued one cycle earlier.
- R3: If only the MEM/WB tag has its write enable set and its destination equals a source index, that operand's select is 01 and the operand equals `wb_value`. The MEM/WB tag is the one from the instruction issued two cycles earlier.
- R4: If both tag stages match the same source index, the select is 10 and the EX/MEM value is used.
- R5: An instruction issued with `dst_wr` low is never forwarded, even if its destination index matches.
- R6: A destination index of 0 is never forwarded. A source index of 0 with a select of 00 yields the ID/EX value.
- R7: The two operands are resolved independently. Equal source indices always give equal selects.
- R8: With no match, the select is 00 and the operand equals its ID/EX value. The code 11 never appears.
- R9: A destination is no longer considered three cycles after its instruction was issued. The operand then comes from ID/EX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src1_idx | input | REG_AW | First source register index of the execute-stage instruction |
| src2_idx | input | REG_AW | Second source register index of the execute-stage instruction |
| dst_idx | input | REG_AW | Destination index of the execute-stage instruction |
| dst_wr | input | 1 | Execute-stage instruction will write its destination |
| src1_val | input | DATA_W | First operand as read in decode (ID/EX) |
| src2_val | input | DATA_W | Second operand as read in decode (ID/EX) |
| mem_result | input | DATA_W | ALU result held in EX/MEM |
| wb_value | input | DATA_W | Write-back value held in MEM/WB |
| sel1 | output | 2 | First operand select: 00 ID/EX, 10 EX/MEM, 01 MEM/WB |
| sel2 | output | 2 | Second operand select, same encoding |
| opnd1 | output | DATA_W | First ALU operand |
| opnd2 | output | DATA_W | Second ALU operand |

## Verification
Some properties are checked on every clocked cycle:
- the clean select state after reset;
- the link between a select and the ports one or two cycles earlier;
- EX/MEM priority when both stages match;
- that register zero is never forwarded;
- that equal source indices give equal selects;
- that the operand follows its select.

Only the bench's scenarios can show that the forwarded operand actually equals the architectural register value. To do this, the bench replays back-to-back dependent add and subtract chains against a reference register model. Those scenarios also show that stale ID/EX reads are corrected and that a destination retires after three cycles. They also show that a reset in mid-stream discards the dependencies still in flight.

// File: rtl/alu_fwd_pkg.sv
package alu_fwd_pkg;

   // Operand source select encoding
   typedef enum logic [1:0] {
      FWD_SEL_IDEX  = 2'b00,
      FWD_SEL_WB    = 2'b01,
      FWD_SEL_MEM   = 2'b10
   } fwd_sel_e;

   localparam int unsigned FWD_STAGES = 2;   // EX/MEM, MEM/WB
   localparam int unsigned FWD_OPNDS  = 2;   // two ALU operands

   // Tag stage index (0 = youngest) to select code
   function automatic fwd_sel_e stage_sel(input int unsigned idx);
      fwd_sel_e r;
      r = (idx == 0) ? FWD_SEL_MEM : FWD_SEL_WB;
      return r;
   endfunction

endpackage

// File: rtl/alu_fwd_tag_pipe.sv
module alu_fwd_tag_pipe #(
   parameter int unsigned REG_AW = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_wr,
   input  logic [REG_AW-1:0]                in_dst,
   output logic [STAGES-1:0]                tag_wr,
   output logic [STAGES-1:0][REG_AW-1:0]    tag_dst
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("alu_fwd_tag_pipe: STAGES must be at least 1");
      end
   endgenerate

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  tag_wr[s]  <= 1'b0;
                  tag_dst[s] <= '0;
               end else begin
                  tag_wr[s]  <= in_wr;
                  tag_dst[s] <= in_dst;
               end
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  tag_wr[s]  <= 1'b0;
                  tag_dst[s] <= '0;
               end else begin
                  tag_wr[s]  <= tag_wr[s-1];
                  tag_dst[s] <= tag_dst[s-1];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/alu_fwd_match.sv
module alu_fwd_match
   import alu_fwd_pkg::*;
#(
   parameter int unsigned REG_AW     = 5,
   parameter int unsigned STAGES     = 2,
   parameter bit          ZERO_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0]               src_idx,
   input  logic [STAGES-1:0]               tag_wr,
   input  logic [STAGES-1:0][REG_AW-1:0]   tag_dst,
   output fwd_sel_e                        sel
);

   logic [STAGES-1:0] hit;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_cmp
         if (ZERO_FIXED) begin : g_zero_fixed
            assign hit[s] = tag_wr[s] && (tag_dst[s] != '0) && (tag_dst[s] == src_idx);
         end else begin : g_zero_plain
            assign hit[s] = tag_wr[s] && (tag_dst[s] == src_idx);
         end
      end
   endgenerate

   // Oldest first, younger stages override
   always_comb begin
      sel = FWD_SEL_IDEX;
      for (int i = STAGES - 1; i >= 0; i--) begin
         if (hit[i]) sel = stage_sel(unsigned'(i));
      end
   end

endmodule

// File: rtl/alu_fwd_opmux.sv
module alu_fwd_opmux
   import alu_fwd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  fwd_sel_e              sel,
   input  logic [DATA_W-1:0]     idex_val,
   input  logic [DATA_W-1:0]     mem_val,
   input  logic [DATA_W-1:0]     wb_val,
   output logic [DATA_W-1:0]     opnd
);

   always_comb begin
      unique case (sel)
         FWD_SEL_MEM: opnd = mem_val;
         FWD_SEL_WB:  opnd = wb_val;
         default:     opnd = idex_val;
      endcase
   end

endmodule

// File: rtl/alu_fwd_unit.sv
module alu_fwd_unit
   import alu_fwd_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned REG_AW     = 5,
   parameter bit          ZERO_FIXED = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [REG_AW-1:0]    src1_idx,
   input  logic [REG_AW-1:0]    src2_idx,
   input  logic [REG_AW-1:0]    dst_idx,
   input  logic                 dst_wr,
   input  logic [DATA_W-1:0]    src1_val,
   input  logic [DATA_W-1:0]    src2_val,
   input  logic [DATA_W-1:0]    mem_result,
   input  logic [DATA_W-1:0]    wb_value,
   output logic [1:0]           sel1,
   output logic [1:0]           sel2,
   output logic [DATA_W-1:0]    opnd1,
   output logic [DATA_W-1:0]    opnd2
);

   localparam int unsigned STAGES = FWD_STAGES;
   localparam int unsigned NOPND  = FWD_OPNDS;

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("alu_fwd_unit: DATA_W must be at least 1");
      end
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_reg_aw
         $error("alu_fwd_unit: REG_AW must be within 1..8");
      end
   endgenerate

   logic [STAGES-1:0]               tag_wr;
   logic [STAGES-1:0][REG_AW-1:0]   tag_dst;

   logic [NOPND-1:0][REG_AW-1:0]    src_idx_v;
   logic [NOPND-1:0][DATA_W-1:0]    src_val_v;
   logic [NOPND-1:0][DATA_W-1:0]    opnd_v;
   fwd_sel_e                        sel_v [NOPND];

   assign src_idx_v[0] = src1_idx;
   assign src_idx_v[1] = src2_idx;
   assign src_val_v[0] = src1_val;
   assign src_val_v[1] = src2_val;

   alu_fwd_tag_pipe #(
      .REG_AW (REG_AW),
      .STAGES (STAGES)
   ) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_wr   (dst_wr),
      .in_dst  (dst_idx),
      .tag_wr  (tag_wr),
      .tag_dst (tag_dst)
   );

   genvar g;
   generate
      for (g = 0; g < NOPND; g++) begin : g_opnd
         alu_fwd_match #(
            .REG_AW     (REG_AW),
            .STAGES     (STAGES),
            .ZERO_FIXED (ZERO_FIXED)
         ) u_match (
            .src_idx (src_idx_v[g]),
            .tag_wr  (tag_wr),
            .tag_dst (tag_dst),
            .sel     (sel_v[g])
         );

         alu_fwd_opmux #(
            .DATA_W (DATA_W)
         ) u_mux (
            .sel      (sel_v[g]),
            .idex_val (src_val_v[g]),
            .mem_val  (mem_result),
            .wb_val   (wb_value),
            .opnd     (opnd_v[g])
         );
      end
   endgenerate

   assign sel1  = sel_v[0];
   assign sel2  = sel_v[1];
   assign opnd1 = opnd_v[0];
   assign opnd2 = opnd_v[1];

endmodule

// File: rtl/alu_fwd_unit_chk.sv
module alu_fwd_unit_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned REG_AW     = 5,
   parameter bit          ZERO_FIXED = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [REG_AW-1:0]    src1_idx,
   input logic [REG_AW-1:0]    src2_idx,
   input logic [REG_AW-1:0]    dst_idx,
   input logic                 dst_wr,
   input logic [DATA_W-1:0]    src1_val,
   input logic [DATA_W-1:0]    mem_result,
   input logic [DATA_W-1:0]    wb_value,
   input logic [1:0]           sel1,
   input logic [1:0]           sel2,
   input logic [DATA_W-1:0]    opnd1
);

   // R1
   reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (sel1 == 2'b00 && sel2 == 2'b00));

   // R2
   mem_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(dst_wr) && $past(dst_idx) != '0 && $past(dst_idx) == src1_idx)
      |-> sel1 == 2'b10);

   // R3
   wb_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(dst_wr, 2) && $past(dst_idx, 2) != '0
       && $past(dst_idx, 2) == src1_idx
       && !($past(dst_wr) && $past(dst_idx) == src1_idx))
      |-> sel1 == 2'b01);

   // R4
   mem_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(dst_wr) && $past(dst_wr, 2)
       && $past(dst_idx) == src2_idx && $past(dst_idx, 2) == src2_idx && src2_idx != '0)
      |-> sel2 == 2'b10);

   // R5
   wr_qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel1 == 2'b10) |-> ($past(rst_n) && $past(dst_wr) && $past(dst_idx) == src1_idx));

   generate
      if (ZERO_FIXED) begin : g_zero
         // R6
         zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src1_idx == '0) |-> sel1 == 2'b00);
      end
   endgenerate

   // R7
   same_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src1_idx == src2_idx) |-> sel1 == sel2);

   // R8
   sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel1) && $onehot0(sel2));

   // R8
   opnd_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel1 == 2'b00) |-> opnd1 == src1_val) and
      ((sel1 == 2'b10) |-> opnd1 == mem_result) and
      ((sel1 == 2'b01) |-> opnd1 == wb_value));

endmodule

bind alu_fwd_unit alu_fwd_unit_chk #(
   .DATA_W     (DATA_W),
   .REG_AW     (REG_AW),
   .ZERO_FIXED (ZERO_FIXED)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src1_idx   (src1_idx),
   .src2_idx   (src2_idx),
   .dst_idx    (dst_idx),
   .dst_wr     (dst_wr),
   .src1_val   (src1_val),
   .mem_result (mem_result),
   .wb_value   (wb_value),
   .sel1       (sel1),
   .sel2       (sel2),
   .opnd1      (opnd1)
);

// File: tb/alu_fwd_unit_tb.sv
`timescale 1ns/1ps
module alu_fwd_unit_tb;

   localparam int DW = 32;
   localparam int AW = 5;
   localparam int NREG = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] src1_idx = '0, src2_idx = '0, dst_idx = '0;
   logic          dst_wr = 1'b0;
   logic [DW-1:0] src1_val = '0, src2_val = '0, mem_result = '0, wb_value = '0;
   logic [1:0]    sel1, sel2;
   logic [DW-1:0] opnd1, opnd2;

   always #4 clk = ~clk;   // 125 MHz

   alu_fwd_unit #(.DATA_W(DW), .REG_AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .src1_idx(src1_idx), .src2_idx(src2_idx),
      .dst_idx(dst_idx), .dst_wr(dst_wr),
      .src1_val(src1_val), .src2_val(src2_val),
      .mem_result(mem_result), .wb_value(wb_value),
      .sel1(sel1), .sel2(sel2), .opnd1(opnd1), .opnd2(opnd2)
   );

   typedef struct {
      string         tag;
      logic [1:0]    s1, s2;
      logic [DW-1:0] v1, v2;
   } exp_t;

   exp_t          sb_q [$];
   int            n_chk = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   // Reference models
   logic [DW-1:0] arch  [NREG];   // all older instructions applied
   logic [DW-1:0] rf_wb [NREG];   // register file as seen in decode
   logic          h_wr  [3];      // [0]=1 back, [1]=2 back, [2]=3 back
   logic [AW-1:0] h_dst [3];
   logic [DW-1:0] h_val [3];
   int            n_iss = 0;

   function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
      if (h_wr[0] && h_dst[0] != 0 && h_dst[0] == s) return 2'b10;
      if (h_wr[1] && h_dst[1] != 0 && h_dst[1] == s) return 2'b01;
      return 2'b00;
   endfunction

   task automatic clear_history();
      for (int k = 0; k < 3; k++) begin
         h_wr[k]  = 1'b0;
         h_dst[k] = AW'(k + 1);
         h_val[k] = 32'hDEAD_0000 + DW'(k);
      end
   endtask

   task automatic issue(input bit wr, input logic [AW-1:0] d,
                        input logic [AW-1:0] s1, input logic [AW-1:0] s2,
                        input bit sub, input string tag);
      exp_t e;
      logic [DW-1:0] res;
      @(negedge clk);
      if (h_wr[2] && h_dst[2] != 0) rf_wb[h_dst[2]] = h_val[2];
      src1_idx   = s1;
      src2_idx   = s2;
      src1_val   = rf_wb[s1];
      src2_val   = rf_wb[s2];
      mem_result = h_val[0];
      wb_value   = h_val[1];
      dst_idx    = d;
      dst_wr     = wr;
      e.tag = tag;
      e.s1  = exp_sel(s1);
      e.s2  = exp_sel(s2);
      e.v1  = arch[s1];
      e.v2  = arch[s2];
      sb_q.push_back(e);
      n_iss++;
      if (wr) res = sub ? (arch[s1] - arch[s2]) : (arch[s1] + arch[s2]);
      else    res = 32'hBAD0_0000 ^ DW'(n_iss);
      if (wr && d != 0) arch[d] = res;
      h_wr[2]  = h_wr[1];  h_dst[2] = h_dst[1];  h_val[2] = h_val[1];
      h_wr[1]  = h_wr[0];  h_dst[1] = h_dst[0];  h_val[1] = h_val[0];
      h_wr[0]  = wr;       h_dst[0] = d;         h_val[0] = res;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n  = 1'b0;
      dst_wr = 1'b0;
      repeat (2) @(negedge clk);
      for (int r = 0; r < NREG; r++) arch[r] = rf_wb[r];
      clear_history();
      rst_n = 1'b1;
   endtask

   // Monitor: compare popped expectations after each drive
   initial begin
      forever begin
         exp_t e;
         @(negedge clk);
         #2;
         while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_chk++;
            if (sel1 !== e.s1 || opnd1 !== e.v1) begin
               n_fail++;
               $display("FAIL %s operand1: sel=%b opnd=%h expected sel=%b opnd=%h",
                        e.tag, sel1, opnd1, e.s1, e.v1);
            end
            n_chk++;
            if (sel2 !== e.s2 || opnd2 !== e.v2) begin
               n_fail++;
               $display("FAIL %s operand2: sel=%b opnd=%h expected sel=%b opnd=%h",
                        e.tag, sel2, opnd2, e.s2, e.v2);
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < NREG; r++) begin
         arch[r]  = (r == 0) ? '0 : 32'h1000_0000 + DW'(r) * 32'h0000_0101;
         rf_wb[r] = arch[r];
      end
      clear_history();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: first instruction after reset, no forwarding
      issue(1'b1, 5'd5, 5'd1, 5'd2, 1'b0, "R1");
      // R2 + R7: both sources hit the previous destination
      issue(1'b1, 5'd3, 5'd5, 5'd5, 1'b0, "R2_R7");
      // R2 on src1, R3 on src2
      issue(1'b1, 5'd4, 5'd3, 5'd5, 1'b1, "R2_R3");
      // R3 on src1, R2 on src2
      issue(1'b1, 5'd6, 5'd3, 5'd4, 1'b0, "R3");
      // R4: two producers of r7 back to back
      issue(1'b1, 5'd7, 5'd1, 5'd1, 1'b0, "R8");
      issue(1'b1, 5'd7, 5'd7, 5'd2, 1'b1, "R2");
      issue(1'b1, 5'd8, 5'd7, 5'd7, 1'b0, "R4");
      // R5: non-writing producer with a matching index
      issue(1'b0, 5'd9, 5'd1, 5'd2, 1'b0, "R8");
      issue(1'b1, 5'd10, 5'd9, 5'd9, 1'b0, "R5");
      issue(1'b0, 5'd11, 5'd2, 5'd3, 1'b0, "R8");
      issue(1'b1, 5'd12, 5'd1, 5'd2, 1'b0, "R8");
      issue(1'b1, 5'd13, 5'd11, 5'd12, 1'b0, "R5");
      // R6: writes to register zero are not forwarded
      issue(1'b1, 5'd0, 5'd1, 5'd2, 1'b0, "R8");
      issue(1'b1, 5'd14, 5'd0, 5'd0, 1'b0, "R6");
      issue(1'b1, 5'd0, 5'd3, 5'd4, 1'b1, "R8");
      issue(1'b1, 5'd15, 5'd0, 5'd14, 1'b0, "R6");
      // R9: destination retired after three cycles
      issue(1'b1, 5'd16, 5'd1, 5'd2, 1'b0, "R8");
      issue(1'b1, 5'd17, 5'd3, 5'd3, 1'b0, "R8");
      issue(1'b1, 5'd18, 5'd4, 5'd4, 1'b0, "R8");
      issue(1'b1, 5'd19, 5'd16, 5'd16, 1'b1, "R9");
      // R1: reset with writers in flight
      issue(1'b1, 5'd20, 5'd1, 5'd2, 1'b0, "R8");
      issue(1'b1, 5'd21, 5'd20, 5'd1, 1'b0, "R2");
      do_reset();
      issue(1'b1, 5'd22, 5'd21, 5'd20, 1'b0, "R1");
      // Random dependent chains over a few registers
      for (int n = 0; n < 400; n++) begin
         issue(($urandom % 5) != 0, AW'($urandom % 8), AW'($urandom % 8),
               AW'($urandom % 8), ($urandom % 2) != 0, "R8_rand");
      end
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule